// File: doc/BRIEF.md
# Dual-Source ROM Emulation Memory

This block holds a 2K x 8 memory that two masters share. While the block is in Internal mode, a host processor bus owns the memory. The memory then appears as a fixed window in the host address map, from C400h to CBFFh, and each host access can be stretched by a chosen number of wait states. While the block is in External mode, a target board owns the memory through an EPROM-style socket interface, and the target treats it as its boot ROM. A host I/O control port at address 24h selects the owner and drives a reset line to the target.

Target writes are possible but are tightly qualified. A write is taken only when the target's program strobe is high, its address lies in the lowest 2K, and its ordinary read chip select is inactive. A separate enable turns target writes off completely, which leaves a pure read-only simulator. This arrangement lets code on the target copy its registers into the memory, where the host can inspect them later. Stack pushes and other writes to the target's own RAM are never captured.

The host side is one state machine with the states IDLE, WAIT, ACCESS, PORT and DONE. The transitions are:
- IDLE goes to WAIT when a memory request hits the window in Internal mode.
- IDLE goes to PORT when a request hits the I/O port.
- IDLE stays in IDLE for any other request, so that request is not claimed.
- WAIT stays in WAIT while its count is non-zero, then goes to ACCESS.
- ACCESS goes to DONE.
- PORT goes to DONE.
- DONE goes back to IDLE.

Top module: `rom_emu_mem`

## Requirements
- R1: After reset, ext_mode is 0 (Internal), tgt_reset is 1, tgt_drive is 0 and hst_ready is 0. A read of the control port returns 02h.
- R2: In Internal mode, a host memory write or read at an address from C400h to CBFFh inclusive reaches memory word (address - C400h). A read returns the last value written to that word.
- R3: A host memory request outside C400h..CBFFh (for example C3FFh or CC00h) gets no hst_ready and leaves every memory word unchanged.
- R4: An I/O request (hst_io=1) whose hst_addr[7:0] is 24h reaches the control port. Bit 0 is the mode (1 = External) and bit 1 is the target reset (1 = asserted). A read returns both bits in those positions, with bits 7..2 read as 0. An I/O request to any other address gets no hst_ready.
- R5: hst_ready is a one-cycle pulse. For a claimed memory access it comes hst_wait+3 cycles after the cycle in which hst_req is sampled. For a port access it comes 2 cycles after.
- R6: In External mode, with tgt_cs_n=0 and tgt_oe_n=0, tgt_drive is 1 one cycle later, and tgt_rdata holds memory word tgt_addr[10:0].
- R7: In Internal mode, tgt_drive stays 0 and no target strobe changes memory.
- R8: In External mode with tgt_wr_en=1, a cycle with tgt_pgm=1, tgt_cs_n=1 and tgt_addr[15:11]=0 writes tgt_wdata into word tgt_addr[10:0].
- R9: A target write is dropped if tgt_cs_n=0, if tgt_addr[15:11] is non-zero, or if tgt_wr_en=0.
- R10: In External mode, host memory requests get no hst_ready and do not change memory.
- R11: ext_mode and tgt_reset change only in the cycle in which a port write completes (hst_ready=1). A request raised while an access is still pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | Host request pulse, sampled in IDLE |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_io | input | 1 | Host I/O space (1) or memory space (0) |
| hst_addr | input | 16 | Host address |
| hst_wdata | input | 8 | Host write data |
| hst_wait | input | 2 | Wait states inserted on memory accesses |
| hst_ready | output | 1 | Access complete, read data valid |
| hst_rdata | output | 8 | Host read data |
| tgt_addr | input | 16 | Target address |
| tgt_cs_n | input | 1 | Target read chip select, active low |
| tgt_oe_n | input | 1 | Target output enable, active low |
| tgt_pgm | input | 1 | Target program strobe, active high |
| tgt_wdata | input | 8 | Target write data |
| tgt_rdata | output | 8 | Data presented to the target |
| tgt_drive | output | 1 | Enable for the target data buffers |
| tgt_wr_en | input | 1 | Allows qualified target writes |
| ext_mode | output | 1 | Current owner, 1 = target |
| tgt_reset | output | 1 | Reset line to the target |

## Verification
The assertions assume the following about the inputs:
- Target socket signals are synchronous to clk.
- The host pulses hst_req for a single cycle and then waits for hst_ready.
- Any request raised during a pending access is meant to be dropped.

Under these assumptions, the assertions can treat any change of ownership outside a completed port write as an error. They can also treat any drive of the target buffers without a preceding chip-select and output-enable cycle as an error. The stimulus respects these assumptions: it changes inputs only on the falling edge, issues one host request per access, and returns target strobes to idle after each target cycle. The single exception is a directed case that deliberately raises a port write during a wait.

// File: rtl/rom_emu_pkg.sv
package rom_emu_pkg;

    typedef enum logic [2:0] {
        H_IDLE,
        H_WAIT,
        H_ACCESS,
        H_PORT,
        H_DONE
    } hst_state_e;

    localparam int CTL_MODE_BIT = 0;
    localparam int CTL_TRST_BIT = 1;

endpackage

// File: rtl/host_port_fsm.sv
module host_port_fsm
    import rom_emu_pkg::*;
#(
    parameter int AW       = 11,
    parameter int HAW      = 16,
    parameter int DW       = 8,
    parameter int WSW      = 2,
    parameter logic [15:0] WIN_BASE = 16'hC400,
    parameter logic [7:0]  CTL_ADDR = 8'h24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic           we,
    input  logic           io,
    input  logic [HAW-1:0] addr,
    input  logic [DW-1:0]  wdata,
    input  logic [WSW-1:0] wait_sel,
    input  logic [DW-1:0]  ram_q,
    output logic           ready,
    output logic [DW-1:0]  rdata,
    output logic [AW-1:0]  ram_addr,
    output logic           ram_we,
    output logic [DW-1:0]  ram_wdata,
    output logic           mode,
    output logic           trst
);

    localparam int DEPTH = 1 << AW;
    localparam logic [HAW-1:0] WIN_LO = HAW'(WIN_BASE);
    localparam logic [HAW-1:0] WIN_HI = HAW'(int'(WIN_BASE) + DEPTH - 1);

    hst_state_e       state, state_nxt;
    logic [WSW-1:0]   cnt;
    logic [AW-1:0]    addr_q;
    logic             we_q;
    logic [DW-1:0]    data_q;
    logic             win_hit, ctl_hit;
    logic [DW-1:0]    ctl_val;

    assign win_hit = !io && (addr >= WIN_LO) && (addr <= WIN_HI);
    assign ctl_hit = io && (addr[7:0] == CTL_ADDR);

    always_comb begin
        ctl_val = '0;
        ctl_val[CTL_MODE_BIT] = mode;
        ctl_val[CTL_TRST_BIT] = trst;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            H_IDLE: begin
                if (req && ctl_hit)
                    state_nxt = H_PORT;
                else if (req && win_hit && !mode)
                    state_nxt = H_WAIT;
            end
            H_WAIT:   if (cnt == '0) state_nxt = H_ACCESS;
            H_ACCESS: state_nxt = H_DONE;
            H_PORT:   state_nxt = H_DONE;
            H_DONE:   state_nxt = H_IDLE;
            default:  state_nxt = H_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= H_IDLE;
        else        state <= state_nxt;
    end

    // datapath and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            addr_q <= '0;
            we_q   <= 1'b0;
            data_q <= '0;
            mode   <= 1'b0;
            trst   <= 1'b1;
        end else begin
            unique case (state)
                H_IDLE: begin
                    if (req) begin
                        cnt    <= wait_sel;
                        addr_q <= addr[AW-1:0] - WIN_LO[AW-1:0];
                        we_q   <= we;
                        data_q <= wdata;
                    end
                end
                H_WAIT: if (cnt != '0) cnt <= cnt - 1'b1;
                H_PORT: begin
                    if (we_q) begin
                        mode <= data_q[CTL_MODE_BIT];
                        trst <= data_q[CTL_TRST_BIT];
                    end
                end
                default: ;
            endcase
        end
    end

    logic port_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                port_q <= 1'b0;
        else if (state == H_PORT)   port_q <= 1'b1;
        else if (state == H_ACCESS) port_q <= 1'b0;
    end

    // outputs
    always_comb begin
        ready     = (state == H_DONE);
        rdata     = '0;
        if (state == H_DONE) rdata = port_q ? ctl_val : ram_q;
        ram_addr  = addr_q;
        ram_we    = (state == H_ACCESS) && we_q;
        ram_wdata = data_q;
    end

endmodule

// File: rtl/tgt_gate.sv
module tgt_gate #(
    parameter int AW  = 11,
    parameter int HAW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode,
    input  logic           wr_en,
    input  logic [HAW-1:0] addr,
    input  logic           cs_n,
    input  logic           oe_n,
    input  logic           pgm,
    output logic           ram_we,
    output logic           drive
);

    logic low_space;
    logic drive_q;

    assign low_space = (addr[HAW-1:AW] == '0);

    // write only on a program strobe with read select idle
    assign ram_we = mode && wr_en && pgm && cs_n && low_space;

    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= mode && !cs_n && !oe_n;
    end

    assign drive = drive_q && mode;

endmodule

// File: rtl/emu_ram.sv
module emu_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          sel_ext,
    input  logic [AW-1:0] h_addr,
    input  logic          h_we,
    input  logic [DW-1:0] h_wdata,
    input  logic [AW-1:0] t_addr,
    input  logic          t_we,
    input  logic [DW-1:0] t_wdata,
    output logic [DW-1:0] q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] a;
    logic          w;
    logic [DW-1:0] d;

    // address and data source selection
    always_comb begin
        a = sel_ext ? t_addr  : h_addr;
        w = sel_ext ? t_we    : h_we;
        d = sel_ext ? t_wdata : h_wdata;
    end

    always_ff @(posedge clk) begin
        if (w) mem[a] <= d;
        q <= mem[a];
    end

endmodule

// File: rtl/rom_emu_mem.sv
module rom_emu_mem #(
    parameter int AW  = 11,
    parameter int HAW = 16,
    parameter int DW  = 8,
    parameter int WSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hst_req,
    input  logic           hst_we,
    input  logic           hst_io,
    input  logic [HAW-1:0] hst_addr,
    input  logic [DW-1:0]  hst_wdata,
    input  logic [WSW-1:0] hst_wait,
    output logic           hst_ready,
    output logic [DW-1:0]  hst_rdata,
    input  logic [HAW-1:0] tgt_addr,
    input  logic           tgt_cs_n,
    input  logic           tgt_oe_n,
    input  logic           tgt_pgm,
    input  logic [DW-1:0]  tgt_wdata,
    output logic [DW-1:0]  tgt_rdata,
    output logic           tgt_drive,
    input  logic           tgt_wr_en,
    output logic           ext_mode,
    output logic           tgt_reset
);

    logic [AW-1:0] h_ram_addr;
    logic          h_ram_we;
    logic [DW-1:0] h_ram_wdata;
    logic          t_ram_we;
    logic [DW-1:0] ram_q;

    host_port_fsm #(.AW(AW), .HAW(HAW), .DW(DW), .WSW(WSW)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (hst_req),
        .we        (hst_we),
        .io        (hst_io),
        .addr      (hst_addr),
        .wdata     (hst_wdata),
        .wait_sel  (hst_wait),
        .ram_q     (ram_q),
        .ready     (hst_ready),
        .rdata     (hst_rdata),
        .ram_addr  (h_ram_addr),
        .ram_we    (h_ram_we),
        .ram_wdata (h_ram_wdata),
        .mode      (ext_mode),
        .trst      (tgt_reset)
    );

    tgt_gate #(.AW(AW), .HAW(HAW)) u_tgt (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (ext_mode),
        .wr_en  (tgt_wr_en),
        .addr   (tgt_addr),
        .cs_n   (tgt_cs_n),
        .oe_n   (tgt_oe_n),
        .pgm    (tgt_pgm),
        .ram_we (t_ram_we),
        .drive  (tgt_drive)
    );

    emu_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk     (clk),
        .sel_ext (ext_mode),
        .h_addr  (h_ram_addr),
        .h_we    (h_ram_we),
        .h_wdata (h_ram_wdata),
        .t_addr  (tgt_addr[AW-1:0]),
        .t_we    (t_ram_we),
        .t_wdata (tgt_wdata),
        .q       (ram_q)
    );

    assign tgt_rdata = ram_q;

endmodule

// File: rtl/rom_emu_chk.sv
module rom_emu_chk (
    input logic clk,
    input logic rst_n,
    input logic hst_ready,
    input logic tgt_cs_n,
    input logic tgt_oe_n,
    input logic tgt_drive,
    input logic ext_mode,
    input logic tgt_reset
);

    assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ready |=> !hst_ready);

    assert_drive_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_drive |-> $past(!tgt_cs_n && !tgt_oe_n));

    assert_quiet_internal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> !tgt_drive);

    assert_ctl_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ext_mode) || !$stable(tgt_reset)) |-> hst_ready);

endmodule

bind rom_emu_mem rom_emu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_ready (hst_ready),
    .tgt_cs_n  (tgt_cs_n),
    .tgt_oe_n  (tgt_oe_n),
    .tgt_drive (tgt_drive),
    .ext_mode  (ext_mode),
    .tgt_reset (tgt_reset)
);

// File: tb/tb_rom_emu_mem.sv
`timescale 1ns/1ps
module tb_rom_emu_mem;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_req = 1'b0, hst_we = 1'b0, hst_io = 1'b0;
    logic [15:0] hst_addr = '0;
    logic [7:0]  hst_wdata = '0;
    logic [1:0]  hst_wait = '0;
    logic        hst_ready;
    logic [7:0]  hst_rdata;
    logic [15:0] tgt_addr = '0;
    logic        tgt_cs_n = 1'b1, tgt_oe_n = 1'b1, tgt_pgm = 1'b0;
    logic [7:0]  tgt_wdata = '0;
    logic [7:0]  tgt_rdata;
    logic        tgt_drive;
    logic        tgt_wr_en = 1'b1;
    logic        ext_mode, tgt_reset;

    int nvec = 0;
    int nbad = 0;
    logic [7:0] model [2048];

    always #10 clk = ~clk;

    rom_emu_mem dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int mem_lat(input logic [1:0] w);
        return int'(w) + 3;
    endfunction

    function automatic logic tgt_qual(input logic [15:0] a, input logic cs_n, input logic en);
        return en && cs_n && (a[15:11] == 5'd0);
    endfunction

    // one host access; lat = 0 when never claimed
    task automatic host_acc(input logic io, input logic we, input logic [15:0] a,
                            input logic [7:0] wd, input logic [1:0] w,
                            output logic [7:0] rd, output int lat);
        @(negedge clk);
        hst_req = 1'b1; hst_io = io; hst_we = we; hst_addr = a;
        hst_wdata = wd; hst_wait = w;
        lat = 0; rd = '0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (i == 1) hst_req = 1'b0;
            if (hst_ready) begin
                lat = i; rd = hst_rdata;
                break;
            end
        end
    endtask

    task automatic tgt_cyc(input logic [15:0] a, input logic cs_n, input logic oe_n,
                           input logic pgm, input logic [7:0] wd,
                           output logic drv, output logic [7:0] rd);
        @(negedge clk);
        tgt_addr = a; tgt_cs_n = cs_n; tgt_oe_n = oe_n; tgt_pgm = pgm; tgt_wdata = wd;
        @(negedge clk);
        drv = tgt_drive; rd = tgt_rdata;
        tgt_cs_n = 1'b1; tgt_oe_n = 1'b1; tgt_pgm = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        nbad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [7:0]  rd;
        logic        drv;
        int          lat;
        logic [15:0] a;
        logic [7:0]  d;
        logic [1:0]  w;
        void'($urandom(32'd7341));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ext_mode", ext_mode, 0);
        chk("R1 tgt_reset", tgt_reset, 1);
        chk("R1 tgt_drive", tgt_drive, 0);
        chk("R1 hst_ready", hst_ready, 0);
        host_acc(1, 0, 16'h0024, 0, 0, rd, lat);
        chk("R1 ctl read", rd, 8'h02);
        chk("R5 port latency", lat, 2);

        // R2 fill whole window with random data, random wait states
        for (int i = 0; i < 2048; i++) begin
            d = 8'($urandom); w = 2'($urandom);
            host_acc(0, 1, 16'hC400 + 16'(i), d, w, rd, lat);
            model[i] = d;
            if (i % 256 == 0) chk("R5 write latency", lat, mem_lat(w));
        end
        // R2 boundaries
        host_acc(0, 0, 16'hC400, 0, 0, rd, lat);
        chk("R2 read C400", rd, model[0]);
        host_acc(0, 0, 16'hCBFF, 0, 3, rd, lat);
        chk("R2 read CBFF", rd, model[2047]);
        chk("R5 latency w3", lat, 6);
        for (int i = 0; i < 150; i++) begin
            a = 16'($urandom % 2048); w = 2'($urandom);
            host_acc(0, 0, 16'hC400 + a, 0, w, rd, lat);
            chk("R2 random read", rd, model[a]);
            chk("R5 read latency", lat, mem_lat(w));
        end

        // R3 outside window
        host_acc(0, 1, 16'hC3FF, 8'h5A, 0, rd, lat);
        chk("R3 C3FF unclaimed", lat, 0);
        host_acc(0, 1, 16'hCC00, 8'hA5, 0, rd, lat);
        chk("R3 CC00 unclaimed", lat, 0);
        host_acc(0, 0, 16'hC400, 0, 0, rd, lat);
        chk("R3 word 0 kept", rd, model[0]);
        host_acc(0, 0, 16'hCBFF, 0, 0, rd, lat);
        chk("R3 word 7FF kept", rd, model[2047]);
        // R4 other I/O address
        host_acc(1, 1, 16'h0025, 8'h01, 0, rd, lat);
        chk("R4 io 25 unclaimed", lat, 0);
        chk("R4 mode untouched", ext_mode, 0);

        // R7 target strobes in Internal mode
        tgt_cyc(16'h0010, 1, 1, 1, ~model[16], drv, rd);
        chk("R7 no drive on pgm", drv, 0);
        tgt_cyc(16'h0010, 0, 0, 0, 0, drv, rd);
        chk("R7 no drive on read", drv, 0);
        host_acc(0, 0, 16'hC410, 0, 0, rd, lat);
        chk("R7 word kept", rd, model[16]);

        // R11 request during a pending access is dropped
        @(negedge clk);
        hst_req = 1'b1; hst_io = 0; hst_we = 0; hst_addr = 16'hC401; hst_wait = 2'd3;
        @(negedge clk);
        hst_io = 1; hst_we = 1; hst_addr = 16'h0024; hst_wdata = 8'h01;
        @(negedge clk);
        hst_req = 1'b0;
        repeat (6) @(negedge clk);
        chk("R11 busy request dropped", ext_mode, 0);

        // R4 / R11 switch to External with reset released
        host_acc(1, 1, 16'h0024, 8'hFD, 0, rd, lat);
        chk("R11 mode at ready", ext_mode, 1);
        chk("R4 reset bit", tgt_reset, 0);
        host_acc(1, 0, 16'h0024, 0, 0, rd, lat);
        chk("R4 ctl readback", rd, 8'h01);

        // R10 host memory locked out
        host_acc(0, 1, 16'hC400, ~model[0], 0, rd, lat);
        chk("R10 host unclaimed", lat, 0);

        // R6 target reads
        tgt_cyc(16'h0000, 0, 0, 0, 0, drv, rd);
        chk("R10 word 0 kept", rd, model[0]);
        for (int i = 0; i < 150; i++) begin
            a = 16'($urandom % 2048);
            tgt_cyc(a, 0, 0, 0, 0, drv, rd);
            chk("R6 drive", drv, 1);
            chk("R6 data", rd, model[a]);
        end
        tgt_cyc(16'h0005, 0, 1, 0, 0, drv, rd);
        chk("R6 no drive without oe", drv, 0);

        // R8 / R9 target writes
        tgt_cyc(16'h0020, 1, 1, 1, 8'h3C, drv, rd);
        model[32] = 8'h3C;
        tgt_cyc(16'h0020, 0, 0, 1, 8'hC3, drv, rd);
        chk("R9 cs active blocks", rd, 8'h3C);
        tgt_cyc(16'h0820, 1, 1, 1, 8'h77, drv, rd);
        tgt_cyc(16'h0020, 0, 0, 0, 0, drv, rd);
        chk("R9 high space blocked", rd, 8'h3C);
        tgt_wr_en = 1'b0;
        tgt_cyc(16'h0020, 1, 1, 1, 8'h99, drv, rd);
        tgt_cyc(16'h0020, 0, 0, 0, 0, drv, rd);
        chk("R9 disabled blocked", rd, 8'h3C);
        for (int i = 0; i < 200; i++) begin
            logic cs, en;
            a = 16'($urandom % 2048);
            if ($urandom % 4 == 0) a[15:11] = 5'($urandom);
            cs = ($urandom % 4) != 0;
            en = ($urandom % 4) != 0;
            d = 8'($urandom);
            tgt_wr_en = en;
            tgt_cyc(a, cs, 1, 1, d, drv, rd);
            if (tgt_qual(a, cs, en)) model[a[10:0]] = d;
        end
        tgt_wr_en = 1'b1;
        for (int i = 0; i < 100; i++) begin
            a = 16'($urandom % 2048);
            tgt_cyc(a, 0, 0, 0, 0, drv, rd);
            chk("R8 target write result", rd, model[a]);
        end

        // back to Internal; host view matches
        host_acc(1, 1, 16'h0024, 8'h02, 0, rd, lat);
        chk("R11 back internal", ext_mode, 0);
        chk("R4 reset reasserted", tgt_reset, 1);
        host_acc(0, 0, 16'hC420, 0, 1, rd, lat);
        chk("R8 host sees target write", rd, model[32]);
        for (int i = 0; i < 50; i++) begin
            a = 16'($urandom % 2048);
            host_acc(0, 0, 16'hC400 + a, 0, 0, rd, lat);
            chk("R8 host readback", rd, model[a]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule